// File: doc/BRIEF.md
# Dual-Issue Instruction Queue with Branch Side Path

This block sits between the fetch stage and the execution units of a small superscalar core. It holds up to six pre-decoded instructions in program order. Each instruction carries a three-bit unit tag naming its target. Every cycle, fetch offers up to four instructions on packed lanes, with lane 0 the oldest. The block answers in the same cycle with how many it takes. Only the two oldest entries are considered for issue. An entry issues only when its target has a vacancy, and no entry may pass an older one.

The offer from fetch is a count-based valid/ready pair. `fetch_cnt` says how many lanes, counted from lane 0, hold valid instructions. `fetch_acc` says how many of those are written this cycle, and these are always the lowest lanes. Fetch must present any lanes that were not accepted again on a later cycle, shifted down to lane 0. The acceptance depends on this cycle's removals and on `flush`, so it can be lower than the raw free space.

Each execution unit has a vacancy input. Each unit also has an issue strobe and a payload output that are valid in the cycle of hand-over. A branch unit has its own vacancy input and issue strobe, outside the two-unit limit. A synchronous flush empties the queue.

Top module: `iq_dispatch`

## Requirements
- R1: While reset is held, no unit or branch issue strobe is asserted, and an offer of four instructions is answered with `fetch_acc` = 4, because the queue is empty.
- R2: `fetch_acc` equals the smaller of `fetch_cnt` and the free space (six minus occupancy plus this cycle's removals). Lanes are taken from lane 0 upward and are placed behind the surviving entries in lane order.
- R3: Only the two oldest queue entries can issue. An entry in a deeper slot never issues, even when its unit has a vacancy.
- R4: An entry issues only when its target has a vacancy. If the oldest entry cannot issue, the second-oldest does not issue in that cycle either.
- R5: When the two oldest entries name the same execution unit, only the oldest one issues in that cycle.
- R6: Unit tags are 0 = integer A, 1 = integer B, 2 = floating point, 3 = load/store, 4 = system register, 5 = branch. Execution-unit strobe bit u belongs to tag u, and its payload is bits u*16 +: 16 of `eu_data`. At most two entries leave the queue per cycle, and each unit receives at most one of them.
- R7: A tag-5 entry in either of the two oldest slots is removed through the branch path when `br_ready` is high. This happens alongside an execution-unit issue from the other slot, and the payload appears on `br_data`.
- R8: When both of the two oldest entries are branches, only the oldest one is taken in that cycle.
- R9: While `flush` is high, nothing issues and `fetch_acc` is 0. On the next cycle the queue is empty.
- R10: The queue never holds more than six entries. With six entries and no removal, `fetch_acc` is 0. With six entries and two removals, it is at most 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue at the next edge; blocks issue and acceptance |
| fetch_cnt | input | 3 | Number of valid offered lanes, counted from lane 0 (0..4) |
| fetch_unit | input | 12 | Unit tag per lane, lane k at bits 3k +: 3 |
| fetch_data | input | 64 | Payload per lane, lane k at bits 16k +: 16 |
| fetch_acc | output | 3 | Number of lanes written this cycle |
| eu_ready | input | 5 | Vacancy per execution unit, bit u for tag u |
| eu_issue | output | 5 | Issue strobe per execution unit |
| eu_data | output | 80 | Issued payload per execution unit, unit u at bits 16u +: 16 |
| br_ready | input | 1 | Branch unit vacancy |
| br_issue | output | 1 | Branch taken from the queue this cycle |
| br_data | output | 16 | Payload of the taken branch |

## Verification
The assertions assume that fetch keeps `fetch_cnt` within 0..4 and uses only tags 0 to 5. They also assume that reset is applied before any offer is made. The directed stimulus holds to these limits. It changes every input on the falling edge, only from tasks, and samples results just after that, before the next rising edge. The queue contents are never read directly. Each test fills the queue with known tags and payloads, then watches the order and values that come out on the issue ports as the vacancies are opened.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int UNIT_W = 3;
  localparam int NUM_EU = 5;

  typedef enum logic [UNIT_W-1:0] {
    U_INTA = 3'd0,
    U_INTB = 3'd1,
    U_FPU  = 3'd2,
    U_LSU  = 3'd3,
    U_SYS  = 3'd4,
    U_BR   = 3'd5
  } unit_e;
endpackage

// File: rtl/iq_store.sv
// Compacting queue storage: removes a prefix of 0..2 entries and appends
// accepted fetch lanes behind the survivors in one cycle.
module iq_store
  import iq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int FW    = 4,
  parameter int PW    = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int FCW  = $clog2(FW + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [1:0]           rm,
  input  logic [FCW-1:0]       fetch_cnt,
  input  logic [FW*UNIT_W-1:0] fetch_unit,
  input  logic [FW*PW-1:0]     fetch_data,
  output logic [FCW-1:0]       acc,
  output logic [1:0]           hd_vld,
  output logic [2*UNIT_W-1:0]  hd_unit,
  output logic [2*PW-1:0]      hd_data,
  output logic [CW-1:0]        occ
);
  logic [UNIT_W-1:0] q_unit [DEPTH];
  logic [PW-1:0]     q_data [DEPTH];
  logic [UNIT_W-1:0] n_unit [DEPTH];
  logic [PW-1:0]     n_data [DEPTH];
  logic [CW-1:0]     n_occ;

  always_comb begin
    int keep_i;
    int room_i;
    int acc_i;
    int src;
    int lane;
    keep_i = int'(occ) - int'(rm);
    room_i = DEPTH - keep_i;
    acc_i  = (int'(fetch_cnt) < room_i) ? int'(fetch_cnt) : room_i;
    if (flush) acc_i = 0;
    for (int i = 0; i < DEPTH; i++) begin
      n_unit[i] = q_unit[i];
      n_data[i] = q_data[i];
      src  = i + int'(rm);
      lane = i - keep_i;
      if (i < keep_i) begin
        if (src < DEPTH) begin
          n_unit[i] = q_unit[src];
          n_data[i] = q_data[src];
        end
      end else if (lane < acc_i && lane < FW) begin
        n_unit[i] = fetch_unit[lane*UNIT_W +: UNIT_W];
        n_data[i] = fetch_data[lane*PW +: PW];
      end
    end
    n_occ = flush ? '0 : CW'(keep_i + acc_i);
    acc   = FCW'(acc_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= n_occ;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      q_unit[i] <= n_unit[i];
      q_data[i] <= n_data[i];
    end
  end

  assign hd_vld  = {occ >= CW'(2), occ >= CW'(1)};
  assign hd_unit = {q_unit[1], q_unit[0]};
  assign hd_data = {q_data[1], q_data[0]};
endmodule

// File: rtl/iq_pick.sv
// In-order selection over the two oldest slots.
module iq_pick
  import iq_pkg::*;
(
  input  logic                 flush,
  input  logic [1:0]           hd_vld,
  input  logic [2*UNIT_W-1:0]  hd_unit,
  input  logic [NUM_EU-1:0]    eu_ready,
  input  logic                 br_ready,
  output logic [1:0]           take,
  output logic [1:0]           is_br,
  output logic [1:0]           rm
);
  logic [UNIT_W-1:0] u0, u1;
  logic              rdy0, rdy1;

  assign u0 = hd_unit[UNIT_W-1:0];
  assign u1 = hd_unit[2*UNIT_W-1:UNIT_W];
  assign is_br[0] = (u0 == U_BR);
  assign is_br[1] = (u1 == U_BR);

  always_comb begin
    rdy0 = 1'b0;
    rdy1 = 1'b0;
    for (int u = 0; u < NUM_EU; u++) begin
      if (u0 == UNIT_W'(u)) rdy0 = eu_ready[u];
      if (u1 == UNIT_W'(u)) rdy1 = eu_ready[u];
    end
  end

  always_comb begin
    take[0] = hd_vld[0] && !flush && (is_br[0] ? br_ready : rdy0);
    take[1] = take[0] && hd_vld[1] &&
              (is_br[1] ? (br_ready && !is_br[0]) : (rdy1 && (u1 != u0)));
    rm = {1'b0, take[0]} + {1'b0, take[1]};
  end
endmodule

// File: rtl/iq_route.sv
// Steers the issuing slots to per-unit strobes and payloads.
module iq_route
  import iq_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic [1:0]           take,
  input  logic [1:0]           is_br,
  input  logic [2*UNIT_W-1:0]  hd_unit,
  input  logic [2*PW-1:0]      hd_data,
  output logic [NUM_EU-1:0]    eu_issue,
  output logic [NUM_EU*PW-1:0] eu_data,
  output logic                 br_issue,
  output logic [PW-1:0]        br_data
);
  logic [1:0] eu_take;
  assign eu_take = take & ~is_br;

  for (genvar u = 0; u < NUM_EU; u++) begin : g_unit
    logic hit0, hit1;
    assign hit0 = eu_take[0] && (hd_unit[UNIT_W-1:0] == UNIT_W'(u));
    assign hit1 = eu_take[1] && (hd_unit[2*UNIT_W-1:UNIT_W] == UNIT_W'(u));
    assign eu_issue[u] = hit0 || hit1;
    assign eu_data[u*PW +: PW] = hit0 ? hd_data[PW-1:0] :
                                 hit1 ? hd_data[2*PW-1:PW] : '0;
  end

  assign br_issue = |(take & is_br);
  assign br_data  = (take[0] && is_br[0]) ? hd_data[PW-1:0] :
                    (take[1] && is_br[1]) ? hd_data[2*PW-1:PW] : '0;
endmodule

// File: rtl/iq_dispatch.sv
module iq_dispatch
  import iq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int FW    = 4,
  parameter int PW    = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int FCW  = $clog2(FW + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [FCW-1:0]       fetch_cnt,
  input  logic [FW*UNIT_W-1:0] fetch_unit,
  input  logic [FW*PW-1:0]     fetch_data,
  output logic [FCW-1:0]       fetch_acc,
  input  logic [NUM_EU-1:0]    eu_ready,
  output logic [NUM_EU-1:0]    eu_issue,
  output logic [NUM_EU*PW-1:0] eu_data,
  input  logic                 br_ready,
  output logic                 br_issue,
  output logic [PW-1:0]        br_data
);
  logic [1:0]          hd_vld;
  logic [2*UNIT_W-1:0] hd_unit;
  logic [2*PW-1:0]     hd_data;
  logic [CW-1:0]       occ;
  logic [1:0]          take, is_br, rm;

  iq_store #(.DEPTH(DEPTH), .FW(FW), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rm(rm),
    .fetch_cnt(fetch_cnt), .fetch_unit(fetch_unit), .fetch_data(fetch_data),
    .acc(fetch_acc), .hd_vld(hd_vld), .hd_unit(hd_unit), .hd_data(hd_data),
    .occ(occ)
  );

  iq_pick u_pick (
    .flush(flush), .hd_vld(hd_vld), .hd_unit(hd_unit),
    .eu_ready(eu_ready), .br_ready(br_ready),
    .take(take), .is_br(is_br), .rm(rm)
  );

  iq_route #(.PW(PW)) u_route (
    .take(take), .is_br(is_br), .hd_unit(hd_unit), .hd_data(hd_data),
    .eu_issue(eu_issue), .eu_data(eu_data),
    .br_issue(br_issue), .br_data(br_data)
  );
endmodule

// File: rtl/iq_dispatch_chk.sv
module iq_dispatch_chk
  import iq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int FW    = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int FCW  = $clog2(FW + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [FCW-1:0]    fetch_cnt,
  input logic [FCW-1:0]    fetch_acc,
  input logic [NUM_EU-1:0] eu_ready,
  input logic [NUM_EU-1:0] eu_issue,
  input logic              br_ready,
  input logic              br_issue,
  input logic [CW-1:0]     occ
);
  // R2
  acc_le_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_acc <= fetch_cnt);

  // R4
  eu_vacancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eu_issue & ~eu_ready) == '0);

  // R7
  br_vacancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_issue |-> br_ready);

  // R6
  issue_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(eu_issue) + int'(br_issue)) <= 2);

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (eu_issue == '0 && !br_issue && fetch_acc == '0));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0);

  // R10
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
endmodule

bind iq_dispatch iq_dispatch_chk #(.DEPTH(DEPTH), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_cnt(fetch_cnt),
  .fetch_acc(fetch_acc), .eu_ready(eu_ready), .eu_issue(eu_issue),
  .br_ready(br_ready), .br_issue(br_issue), .occ(occ)
);

// File: tb/iq_dispatch_test.sv
module iq_dispatch_test;
  localparam int FW = 4;
  localparam int PW = 16;
  localparam int NEU = 5;

  logic          clk = 1'b0;
  logic          rst_n, flush, br_ready, br_issue;
  logic [2:0]    fetch_cnt, fetch_acc;
  logic [FW*3-1:0]  fetch_unit;
  logic [FW*PW-1:0] fetch_data;
  logic [NEU-1:0]   eu_ready, eu_issue;
  logic [NEU*PW-1:0] eu_data;
  logic [PW-1:0]    br_data;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  iq_dispatch uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_cnt(fetch_cnt),
    .fetch_unit(fetch_unit), .fetch_data(fetch_data), .fetch_acc(fetch_acc),
    .eu_ready(eu_ready), .eu_issue(eu_issue), .eu_data(eu_data),
    .br_ready(br_ready), .br_issue(br_issue), .br_data(br_data)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive on the falling edge, settle 1 ns, leave checks to the caller.
  task automatic step(bit fl, int n, int u0, int u1, int u2, int u3,
                      int d0, int d1, int d2, int d3, int rdy, bit brr);
    @(negedge clk);
    flush      = fl;
    fetch_cnt  = 3'(n);
    fetch_unit = {3'(u3), 3'(u2), 3'(u1), 3'(u0)};
    fetch_data = {16'(d3), 16'(d2), 16'(d1), 16'(d0)};
    eu_ready   = 5'(rdy);
    br_ready   = brr;
    #1;
  endtask

  task automatic idle(int rdy, bit brr);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, rdy, brr);
  endtask

  function automatic int eud(int u);
    return int'(eu_data[u*PW +: PW]);
  endfunction

  task automatic t_reset;
    rst_n = 1'b0;
    step(0, 4, 0, 1, 2, 3, 1, 2, 3, 4, 5'h1F, 1);
    repeat (2) @(posedge clk);
    #1;
    chk("R1 eu_issue in reset", int'(eu_issue), 0);
    chk("R1 br_issue in reset", int'(br_issue), 0);
    chk("R1 fetch_acc in reset", int'(fetch_acc), 4);
    idle(0, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_fill;
    step(0, 4, 0, 1, 2, 3, 1, 2, 3, 4, 0, 0);
    chk("R2 accept into empty", int'(fetch_acc), 4);
    chk("R4 no vacancy no issue", int'(eu_issue), 0);
    step(0, 4, 4, 5, 0, 0, 5, 6, 7, 8, 0, 0);
    chk("R2 accept limited by space", int'(fetch_acc), 2);
    step(0, 3, 0, 0, 0, 0, 9, 9, 9, 0, 0, 0);
    chk("R10 full queue accepts none", int'(fetch_acc), 0);
  endtask

  task automatic t_order;
    idle(5'b00010, 0);
    chk("R4 younger waits for older", int'(eu_issue), 0);
    idle(5'b01100, 1);
    chk("R3 deeper slots never issue", int'(eu_issue), 0);
    chk("R3 deeper branch not taken", int'(br_issue), 0);
  endtask

  task automatic t_dual;
    step(0, 2, 2, 2, 0, 0, 9, 10, 0, 0, 5'b00011, 0);
    chk("R6 two integer issues", int'(eu_issue), 5'b00011);
    chk("R6 int A payload", eud(0), 1);
    chk("R6 int B payload", eud(1), 2);
    chk("R10 full with two removals", int'(fetch_acc), 2);
    idle(5'h1F, 0);
    chk("R2 appended order fpu+lsu", int'(eu_issue), 5'b01100);
    chk("R2 fpu payload", eud(2), 3);
    chk("R2 lsu payload", eud(3), 4);
  endtask

  task automatic t_branch;
    idle(5'h1F, 1);
    chk("R7 system issue beside branch", int'(eu_issue), 5'b10000);
    chk("R7 system payload", eud(4), 5);
    chk("R7 branch from slot 1", int'(br_issue), 1);
    chk("R7 branch payload", int'(br_data), 6);
  endtask

  task automatic t_conflict;
    idle(5'h1F, 0);
    chk("R5 same unit only oldest", int'(eu_issue), 5'b00100);
    chk("R5 oldest payload", eud(2), 9);
    idle(5'h1F, 0);
    chk("R5 younger next cycle", int'(eu_issue), 5'b00100);
    chk("R5 younger payload", eud(2), 10);
    idle(5'h1F, 1);
    chk("R3 empty queue no issue", int'(eu_issue) + int'(br_issue), 0);
  endtask

  task automatic t_brpair;
    step(0, 3, 5, 5, 0, 0, 20, 21, 22, 0, 0, 0);
    chk("R2 accept three", int'(fetch_acc), 3);
    idle(5'h1F, 1);
    chk("R8 one branch per cycle", int'(br_issue), 1);
    chk("R8 oldest branch payload", int'(br_data), 20);
    chk("R8 no unit issue", int'(eu_issue), 0);
    idle(5'h1F, 1);
    chk("R7 branch in slot 0", int'(br_data), 21);
    chk("R7 int A beside branch", int'(eu_issue), 5'b00001);
    chk("R7 int A payload", eud(0), 22);
  endtask

  task automatic t_flush;
    step(0, 4, 0, 1, 2, 3, 30, 31, 32, 33, 0, 0);
    chk("R9 preload accepted", int'(fetch_acc), 4);
    step(1, 2, 4, 4, 0, 0, 40, 41, 0, 0, 5'h1F, 1);
    chk("R9 flush blocks issue", int'(eu_issue) + int'(br_issue), 0);
    chk("R9 flush blocks accept", int'(fetch_acc), 0);
    idle(5'h1F, 1);
    chk("R9 queue empty after flush", int'(eu_issue) + int'(br_issue), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_order();
    t_dual();
    t_branch();
    t_conflict();
    t_brpair();
    t_flush();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule